// File: doc/BRIEF.md
# Shared-Clock Three-Lane Serial Sub-Channel Output

This block takes decoded byte streams for up to three selected sub-channels and sends each one bit-serially to a downstream source decoder. One free-running bit clock is shared by all lanes. Each lane has its own data line and its own per-bit valid line, so a receiver takes a bit only in the bit periods where its lane flags a real payload bit.

The bit clock comes from the system clock through a fixed divider. With the default ratio of 64, a 24.576 MHz system clock gives 384 kHz. Receivers sample on the rising edge of the bit clock, so every data and valid change is placed on the system-clock edge where the bit clock falls.

Each lane has a small FIFO filled through a valid/ready handshake and gated by an enable bit from the register file. Bytes leave most significant bit first, and the bytes in a FIFO follow one another with no gap. The upstream scheduler chooses the sub-channel rates so that their sum stays within one bit clock's capacity.

Top module: `subch_serial_out`

## Requirements
- R1: `sclk` is low after reset and then toggles every DIV/2 system clocks: period DIV cycles, 50% duty, first rise DIV/2 cycles after reset release.
- R2: `sdata[i]` and `svalid[i]` change only on the system-clock edge on which `sclk` falls.
- R3: A byte is sent on 8 consecutive bit periods with `svalid[i]` high, bit 7 first and bit 0 last.
- R4: A byte already waiting in a lane's FIFO when the previous byte ends follows without an idle bit period, so consecutive bytes finish 8*DIV cycles apart.
- R5: In any bit period with no payload bit, `svalid[i]` is low and `sdata[i]` is low.
- R6: The lanes are independent. Bytes queued on several lanes at once are sent concurrently, each on its own lines and under the one shared `sclk`.
- R7: `in_ready[i]` is high exactly when lane i is enabled and its FIFO (DEPTH bytes) is not full. A byte is taken on a cycle with `in_valid[i]` and `in_ready[i]` both high.
- R8: While `ch_en[i]` is low, `in_ready[i]` is low and input is ignored. The lane's FIFO is emptied, `svalid[i]` is low from the next `sclk` fall, and `ovf_err[i]` is not set.
- R9: `ovf_err[i]` is set when `in_valid[i]` is high on an enabled lane whose FIFO is full. It stays set until reset.
- R10: During and right after reset, `sclk`, `sdata`, `svalid` and `ovf_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NCH | Per-lane enable from the register file |
| in_data | input | NCH*8 | Per-lane input byte, lane i in bits [8i+7:8i] |
| in_valid | input | NCH | Per-lane input byte valid |
| in_ready | output | NCH | Per-lane input ready |
| sclk | output | 1 | Shared serial bit clock |
| sdata | output | NCH | Per-lane serial data |
| svalid | output | NCH | Per-lane bit valid |
| ovf_err | output | NCH | Per-lane sticky overflow flag |

## Verification
The assertions assume that reset is held for at least one cycle at start-up. They also allow `ch_en` to change on any cycle and `in_valid` to be held while `in_ready` is low, since that case is how an overflow is produced. The bench changes inputs only on falling system-clock edges. Before each timing-sensitive push it waits for an `sclk` rise, so that a push and a following disable land in the same bit period. It also checks that no byte is left after a FIFO is discarded.

// File: rtl/subch_pkg.sv
package subch_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] sbyte_t;
endpackage

// File: rtl/subch_bitclk.sv
module subch_bitclk #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic fall_tick
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt;

  assign fall_tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (cnt == MID) sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/subch_fifo.sv
module subch_fifo
  import subch_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   flush,
  input  logic   push,
  input  sbyte_t wdata,
  input  logic   pop,
  output sbyte_t rdata,
  output logic   full,
  output logic   empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  sbyte_t        mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end
endmodule

// File: rtl/subch_shifter.sv
module subch_shifter
  import subch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   fall_tick,
  input  logic   empty,
  input  sbyte_t head,
  output logic   pop,
  output logic   sdata,
  output logic   svalid
);
  sbyte_t     sreg;
  logic [3:0] left;

  assign pop = fall_tick && en && (left == '0) && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      left   <= '0;
      sdata  <= 1'b0;
      svalid <= 1'b0;
    end else if (fall_tick) begin
      if (!en) begin
        left   <= '0;
        sdata  <= 1'b0;
        svalid <= 1'b0;
      end else if (left != '0) begin
        sdata  <= sreg[BYTE_W-1];
        sreg   <= sreg << 1;
        left   <= left - 1'b1;
        svalid <= 1'b1;
      end else if (!empty) begin
        sdata  <= head[BYTE_W-1];
        sreg   <= head << 1;
        left   <= 4'(BYTE_W - 1);
        svalid <= 1'b1;
      end else begin
        sdata  <= 1'b0;
        svalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/subch_serial_out.sv
module subch_serial_out
  import subch_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DIV   = 64,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH*BYTE_W-1:0] in_data,
  input  logic [NCH-1:0]        in_valid,
  output logic [NCH-1:0]        in_ready,
  output logic                  sclk,
  output logic [NCH-1:0]        sdata,
  output logic [NCH-1:0]        svalid,
  output logic [NCH-1:0]        ovf_err
);
  logic fall_tick;

  subch_bitclk #(.DIV(DIV)) u_bitclk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .fall_tick (fall_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    logic   full, empty, push, pop;
    sbyte_t head;

    assign in_ready[i] = ch_en[i] && !full;
    assign push        = in_valid[i] && in_ready[i];

    subch_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .flush (!ch_en[i]),
      .push  (push),
      .wdata (in_data[i*BYTE_W +: BYTE_W]),
      .pop   (pop),
      .rdata (head),
      .full  (full),
      .empty (empty)
    );

    subch_shifter u_shift (
      .clk       (clk),
      .rst       (rst),
      .en        (ch_en[i]),
      .fall_tick (fall_tick),
      .empty     (empty),
      .head      (head),
      .pop       (pop),
      .sdata     (sdata[i]),
      .svalid    (svalid[i])
    );

    always_ff @(posedge clk) begin
      if (rst) ovf_err[i] <= 1'b0;
      else if (ch_en[i] && in_valid[i] && full) ovf_err[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/subch_serial_out_chk.sv
module subch_serial_out_chk #(
  parameter int NCH = 3,
  parameter int DIV = 64
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] in_valid,
  input logic [NCH-1:0] in_ready,
  input logic           sclk,
  input logic [NCH-1:0] sdata,
  input logic [NCH-1:0] svalid,
  input logic [NCH-1:0] ovf_err
);
  localparam int HALF = DIV / 2;

  logic        sclk_d, seen;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      seen   <= 1'b0;
      gap    <= 32'd1;
    end else begin
      sclk_d <= sclk;
      if (sclk != sclk_d) begin
        seen <= 1'b1;
        gap  <= 32'd1;
      end else begin
        gap <= gap + 32'd1;
      end
    end
  end

  p_sclk_half_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk != sclk_d) && seen |-> gap == HALF);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_edge_valid_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(svalid[i]) |-> $fell(sclk));
    p_edge_data_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(sdata[i]) |-> $fell(sclk));
    p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
      !svalid[i] |-> !sdata[i]);
    p_ready_gate_r8: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |-> !in_ready[i]);
    p_no_ovf_off_r8: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] && !ovf_err[i] |=> !ovf_err[i]);
    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (rst)
      ovf_err[i] |=> ovf_err[i]);
    p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
      ch_en[i] && in_valid[i] && !in_ready[i] |=> ovf_err[i]);
  end
endmodule

bind subch_serial_out subch_serial_out_chk #(.NCH(NCH), .DIV(DIV)) u_chk (.*);

// File: tb/tb_subch_serial_out.sv
`timescale 1ns/1ps
module tb_subch_serial_out;
  localparam int NCH = 3;
  localparam int DIV = 64;
  localparam int DEPTH = 4;
  localparam int BYTEP = 8 * DIV;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   ch_en = '0;
  logic [NCH*8-1:0] in_data = '0;
  logic [NCH-1:0]   in_valid = '0;
  logic [NCH-1:0]   in_ready, sdata, svalid, ovf_err;
  logic             sclk;

  int total = 0, bad = 0;

  subch_serial_out #(.NCH(NCH), .DIV(DIV), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .sclk(sclk),
    .sdata(sdata), .svalid(svalid), .ovf_err(ovf_err));

  always #5 clk = ~clk;

  // Monitor: samples on falling system-clock edges.
  int         cyc = 0, last_rise = -1, rise_n = 0;
  int         per_bad = 0, duty_bad = 0, edge_bad = 0, idle_bad = 0;
  logic       ps = 1'b0;
  logic [NCH-1:0] pd = '0, pv = '0;
  logic [7:0] asm_b [NCH];
  int         nb [NCH];
  int         vb [NCH];
  logic [7:0] rx [NCH][64];
  int         rx_t [NCH][64];
  int         rx_n [NCH];

  initial begin
    for (int c = 0; c < NCH; c++) begin
      nb[c] = 0; vb[c] = 0; rx_n[c] = 0; asm_b[c] = '0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      for (int c = 0; c < NCH; c++)
        if ((sdata[c] !== pd[c] || svalid[c] !== pv[c]) && !(ps === 1'b1 && sclk === 1'b0))
          edge_bad++;
      if (sclk === 1'b1 && ps === 1'b0) begin
        if (last_rise >= 0 && cyc - last_rise != DIV) per_bad++;
        last_rise = cyc;
        rise_n++;
        for (int c = 0; c < NCH; c++) begin
          if (svalid[c] === 1'b1) begin
            vb[c]++;
            asm_b[c] = {asm_b[c][6:0], sdata[c]};
            nb[c]++;
            if (nb[c] == 8) begin
              nb[c] = 0;
              if (rx_n[c] < 64) begin
                rx[c][rx_n[c]] = asm_b[c];
                rx_t[c][rx_n[c]] = cyc;
              end
              rx_n[c]++;
            end
          end else if (sdata[c] !== 1'b0) begin
            idle_bad++;
          end
        end
      end
      if (sclk === 1'b0 && ps === 1'b1 && last_rise >= 0 && cyc - last_rise != DIV / 2)
        duty_bad++;
    end
    ps = sclk; pd = sdata; pv = svalid;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_rise();
    @(negedge clk);
    while (!(sclk === 1'b1 && ps === 1'b0)) @(negedge clk);
  endtask

  task automatic push(input int ch, input logic [7:0] b);
    logic took;
    in_data[ch*8 +: 8] = b;
    in_valid[ch] = 1'b1;
    do begin
      took = in_ready[ch];
      @(negedge clk);
    end while (!took);
    in_valid[ch] = 1'b0;
  endtask

  task automatic wait_rx(input int ch, input int n);
    int lim = 0;
    while (rx_n[ch] < n && lim < 20 * BYTEP) begin
      @(negedge clk); lim++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 sclk", sclk, 0);
    check("R10 svalid", svalid, 0);
    check("R10 sdata", sdata, 0);
    check("R10 ovf_err", ovf_err, 0);
    @(negedge clk); rst = 1'b0;
    check("R8 ready while disabled", in_ready, 0);
  endtask

  task automatic t_single();
    int b0 = rx_n[0];
    ch_en[0] = 1'b1;
    @(negedge clk);
    check("R7 ready when enabled", in_ready[0], 1);
    push(0, 8'hA5);
    wait_rx(0, b0 + 1);
    check("R3 byte count", rx_n[0] - b0, 1);
    check("R3 msb first A5", rx[0][b0], 8'hA5);
    repeat (2 * DIV) @(negedge clk);
    check("R5 no extra valid bits", vb[0], 8 * rx_n[0]);
  endtask

  task automatic t_concurrent();
    int s0 = rx_n[0], s1 = rx_n[1], s2 = rx_n[2];
    ch_en = 3'b111;
    sync_rise();
    push(0, 8'h3C); push(1, 8'h81); push(2, 8'hF0);
    push(0, 8'h0F); push(1, 8'h7E); push(2, 8'h01);
    wait_rx(0, s0 + 2); wait_rx(1, s1 + 2); wait_rx(2, s2 + 2);
    check("R6 lane0 b0", rx[0][s0], 8'h3C);
    check("R6 lane0 b1", rx[0][s0+1], 8'h0F);
    check("R6 lane1 b0", rx[1][s1], 8'h81);
    check("R6 lane1 b1", rx[1][s1+1], 8'h7E);
    check("R6 lane2 b0", rx[2][s2], 8'hF0);
    check("R6 lane2 b1", rx[2][s2+1], 8'h01);
    check("R6 same finish time", rx_t[0][s0+1] - rx_t[2][s2+1], 0);
  endtask

  task automatic t_back_to_back();
    int s = rx_n[0];
    sync_rise();
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h44); push(0, 8'h88);
    wait_rx(0, s + 4);
    check("R4 b0", rx[0][s], 8'h11);
    check("R4 b3", rx[0][s+3], 8'h88);
    for (int k = 1; k < 4; k++)
      check("R4 byte spacing", rx_t[0][s+k] - rx_t[0][s+k-1], BYTEP);
  endtask

  task automatic t_disable();
    int v = vb[1], n = rx_n[1];
    ch_en[1] = 1'b1;
    sync_rise();
    push(1, 8'hC3);
    ch_en[1] = 1'b0;
    in_valid[1] = 1'b1;
    in_data[15:8] = 8'h99;
    repeat (10) @(negedge clk);
    check("R8 ready low when disabled", in_ready[1], 0);
    in_valid[1] = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    check("R8 no valid while disabled", vb[1] - v, 0);
    check("R8 no ovf while disabled", ovf_err[1], 0);
    ch_en[1] = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    check("R8 fifo discarded", vb[1] - v, 0);
    check("R8 no byte out", rx_n[1] - n, 0);
  endtask

  task automatic t_overflow();
    int s = rx_n[2];
    ch_en[2] = 1'b1;
    check("R9 clear before", ovf_err[2], 0);
    sync_rise();
    in_valid[2] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      in_data[23:16] = 8'(8'h50 + k);
      @(negedge clk);
    end
    in_valid[2] = 1'b0;
    check("R9 set on overflow", ovf_err[2], 1);
    check("R7 full deasserts ready", in_ready[2], 0);
    wait_rx(2, s + 4);
    repeat (2 * BYTEP) @(negedge clk);
    check("R7 accepted count", rx_n[2] - s, DEPTH);
    check("R7 first accepted", rx[2][s], 8'h50);
    check("R7 last accepted", rx[2][s+3], 8'h53);
    check("R9 sticky after drain", ovf_err[2], 1);
    check("R9 other lanes clear", ovf_err[1:0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_concurrent();
    t_back_to_back();
    t_disable();
    t_overflow();
    check("R1 rises seen", (rise_n > 10) ? 1 : 0, 1);
    check("R1 period", per_bad, 0);
    check("R1 duty", duty_bad, 0);
    check("R2 edge alignment", edge_bad, 0);
    check("R5 idle data low", idle_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule